// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. A caller supplies an enable strobe that pulses at one, sixteen, thirty-two or sixty-four times the bit rate. The block looks for a start bit and samples the data bits at their centres. It assembles the data least significant bit first, optionally checks a parity bit, and samples the stop bit. The finished character goes into a one-entry receive buffer and a ready flag is raised.

Two 8-bit control words configure the receiver. The receive control word holds the enable bit and the character length. The mode word holds the parity controls and the rate multiplier. The block reports errors in two ways. Parity and overrun errors are sticky until an error-clear command. The framing indication describes only the most recent character. A break is reported when a character of all-zero bits arrives, including the stop bit and any parity bit. A single-cycle event marks both the start of the break and its end.

Top module: `serial_rx_core`

## Requirements
- R1: `rx_ctrl[0]` enables the receiver. While it is 0, activity on the line produces no character and no flag change.
- R2: Data bits are assembled least significant bit first. After the stop bit is sampled, the character appears on `rx_data` and `rx_ready` rises.
- R3: The character length comes from `rx_ctrl[7:6]`: 00 gives 5 bits, 10 gives 6 bits, 01 gives 7 bits and 11 gives 8 bits. `rx_data` bits above the length read 0.
- R4: `rx_mode[0]` enables a parity bit after the data. `rx_mode[1]`=1 selects even parity and 0 selects odd parity. A mismatch sets `par_err`.
- R5: `par_err` and `ovr_err` stay set until an `err_clear` pulse clears both. A later clean character does not clear them.
- R6: If a character completes while `rx_ready` is still set and no read happens in that cycle, the new character replaces the buffer and `ovr_err` is set.
- R7: A `rd_strobe` pulse clears `rx_ready`.
- R8: `frm_err` equals 1 exactly when the stop bit of the most recent character was sampled as 0. The next character replaces its value.
- R9: A character whose data bits, parity bit and stop bit are all 0 sets `brk_flag` and pulses `brk_evt` for one cycle.
- R10: When the line returns high after a break, `brk_flag` clears and `brk_evt` pulses a second time. The receiver hunts for a new start bit only once the line is high.
- R11: At x16 and above, the start bit is checked again half a bit after the falling edge. A line that is high by then is discarded without producing a character.
- R12: The multiplier comes from `rx_mode[7:6]`: 00 gives x1, 01 gives x16, 10 gives x32 and 11 gives x64. The line is sampled only on cycles where `tick` is 1. At x1, every tick takes one sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling enable at the multiplier rate |
| rx_line | input | 1 | Serial input, idle high |
| rx_ctrl | input | 8 | Receive control: bit 0 enable, bits 7:6 length code |
| rx_mode | input | 8 | Mode: bit 0 parity enable, bit 1 even, bits 7:6 multiplier |
| rd_strobe | input | 1 | Buffer read, clears ready |
| err_clear | input | 1 | Clears the sticky parity and overrun flags |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Character available |
| brk_flag | output | 1 | Break in progress |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun |
| frm_err | output | 1 | Framing error of the last character |
| brk_evt | output | 1 | One-cycle pulse at break start and at break end |

## Verification
The bench runs every length code with data whose high bits are set. A decoder that mapped the swapped 6-bit and 7-bit codes wrongly would drop or invent a bit, and masking errors would leak high bits. A clean character follows each parity error and each overrun. A design that cleared those flags on new data, instead of on the clear command, would lose them there. Framing is checked the opposite way, because a latched framing flag would survive the next good character. Further tests cover a glitch shorter than half a bit at x16, a held-low break with its release, and characters at x1 and x64. These show a receiver that skips the mid-bit recheck, restarts inside a break, or miscounts ticks per bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_DW = 8;

  typedef struct packed {
    logic [SRX_DW-1:0] data;
    logic              par_bad;
    logic              frm_bad;
    logic              brk;
  } srx_char_t;

  // length code -> number of data bits (bit 7 and bit 6 are not binary weighted)
  function automatic int unsigned char_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 5;
      2'b10:   return 6;
      2'b01:   return 7;
      default: return 8;
    endcase
  endfunction

  // multiplier code -> ticks per bit
  function automatic int unsigned ticks_per_bit(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  // 1 when received parity bit disagrees with the selected sense
  function automatic logic parity_bad(input logic [SRX_DW-1:0] d,
                                      input int unsigned n,
                                      input logic even,
                                      input logic pbit);
    logic acc;
    acc = pbit;
    for (int i = 0; i < SRX_DW; i++)
      if (i < int'(n)) acc ^= d[i];
    return even ? acc : ~acc;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= 1'b1;
        else if (s == 0) pipe[s] <= din;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int unsigned DW      = SRX_DW,
  parameter int unsigned MAX_TPB = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       en,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] mult_code,
  output logic       done_evt,
  output srx_char_t  chr,
  output logic       brk_end_evt
);
  localparam int unsigned CW = $clog2(MAX_TPB);
  localparam int unsigned BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [DW-1:0]   shreg;
  logic            pbit;
  logic            brk_active;

  logic [CW-1:0]   tpb_m1, half_m1;
  logic [BW-1:0]   last_bit;
  logic            single_tick;
  logic            at_sample, at_mid;
  logic            is_brk;

  always_comb begin
    tpb_m1      = CW'(ticks_per_bit(mult_code) - 1);
    half_m1     = CW'(ticks_per_bit(mult_code) / 2 - 1);
    single_tick = (ticks_per_bit(mult_code) == 1);
    last_bit    = BW'(char_bits(len_code) - 1);
    at_sample   = tick && (cnt == tpb_m1);
    at_mid      = tick && (cnt == half_m1);
    is_brk      = (shreg == '0) && !line && !(par_en && pbit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0; pbit <= 1'b0;
      brk_active <= 1'b0; done_evt <= 1'b0; brk_end_evt <= 1'b0; chr <= '0;
    end else begin
      done_evt    <= 1'b0;
      brk_end_evt <= 1'b0;
      if (!en) begin
        st <= S_IDLE; cnt <= '0; brk_active <= 1'b0;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!line) begin
            cnt <= '0; bitn <= '0; shreg <= '0; pbit <= 1'b0;
            st  <= single_tick ? S_DATA : S_START;
          end
          S_START: begin
            if (at_mid) begin
              cnt <= '0;
              st  <= line ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (at_sample) begin
              cnt         <= '0;
              shreg[bitn] <= line;
              bitn        <= bitn + 1'b1;
              if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (at_sample) begin
              cnt <= '0; pbit <= line; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (at_sample) begin
              cnt          <= '0;
              done_evt     <= 1'b1;
              chr.data     <= shreg;
              chr.par_bad  <= par_en && parity_bad(shreg, char_bits(len_code), par_even, pbit);
              chr.frm_bad  <= !line;
              chr.brk      <= is_brk;
              brk_active   <= is_brk;
              st           <= line ? S_IDLE : S_HOLD;
            end else cnt <= cnt + 1'b1;
          end
          S_HOLD: if (line) begin
            st          <= S_IDLE;
            brk_end_evt <= brk_active;
            brk_active  <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int unsigned DW = SRX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_evt,
  input  srx_char_t     chr,
  input  logic          brk_end_evt,
  input  logic          rd_strobe,
  input  logic          err_clear,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          brk_flag,
  output logic          par_err,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          brk_evt
);
  logic overrun_now;
  assign overrun_now = done_evt && rx_ready && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_ready <= 1'b0; brk_flag <= 1'b0; par_err <= 1'b0;
      ovr_err <= 1'b0; frm_err <= 1'b0; brk_evt <= 1'b0;
    end else begin
      brk_evt <= (done_evt && chr.brk) || brk_end_evt;
      if (done_evt) begin
        rx_data  <= chr.data;
        rx_ready <= 1'b1;
        frm_err  <= chr.frm_bad;
      end else if (rd_strobe) rx_ready <= 1'b0;

      if (done_evt && chr.par_bad) par_err <= 1'b1;
      else if (err_clear)          par_err <= 1'b0;

      if (overrun_now)    ovr_err <= 1'b1;
      else if (err_clear) ovr_err <= 1'b0;

      if (done_evt && chr.brk) brk_flag <= 1'b1;
      else if (brk_end_evt)    brk_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int unsigned DW          = SRX_DW,
  parameter int unsigned MAX_TPB     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_line,
  input  logic [7:0]    rx_ctrl,
  input  logic [7:0]    rx_mode,
  input  logic          rd_strobe,
  input  logic          err_clear,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          brk_flag,
  output logic          par_err,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          brk_evt
);
  logic      line_s;
  logic      done_evt;
  logic      brk_end_evt;
  srx_char_t chr;
  logic      unused_cfg;

  assign unused_cfg = ^{rx_ctrl[5:1], rx_mode[5:2]};

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  srx_frame #(.DW(DW), .MAX_TPB(MAX_TPB)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .en(rx_ctrl[0]), .len_code(rx_ctrl[7:6]),
    .par_en(rx_mode[0]), .par_even(rx_mode[1]), .mult_code(rx_mode[7:6]),
    .done_evt(done_evt), .chr(chr), .brk_end_evt(brk_end_evt)
  );

  srx_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .chr(chr),
    .brk_end_evt(brk_end_evt), .rd_strobe(rd_strobe), .err_clear(err_clear),
    .rx_data(rx_data), .rx_ready(rx_ready), .brk_flag(brk_flag),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err), .brk_evt(brk_evt)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic rd_strobe,
  input logic err_clear,
  input logic done_evt,
  input logic brk_end_evt,
  input logic rx_ready,
  input logic par_err,
  input logic ovr_err,
  input logic frm_err,
  input logic brk_flag
);
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rx_ready); // R2
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clear) |=> par_err); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !err_clear) |=> ovr_err); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !done_evt) |=> (!par_err && !ovr_err)); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && rx_ready && !rd_strobe) |=> ovr_err); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done_evt) |=> !rx_ready); // R7
  AST_FRM_PER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(frm_err)); // R8
  AST_BRK_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end_evt |=> !brk_flag); // R10
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(tick)); // R12
endmodule

bind serial_rx_core srx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_strobe(rd_strobe),
  .err_clear(err_clear), .done_evt(done_evt), .brk_end_evt(brk_end_evt),
  .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err),
  .frm_err(frm_err), .brk_flag(brk_flag)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] rx_ctrl = 8'h00;
  logic [7:0] rx_mode = 8'h00;
  logic       rd_strobe = 1'b0;
  logic       err_clear = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, brk_flag, par_err, ovr_err, frm_err, brk_evt;
  logic [1:0] tcnt = 2'd0;
  logic       tick;
  int         n_chk = 0, n_bad = 0, brk_pulses = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);
  always @(posedge clk) if (brk_evt) brk_pulses++;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
    .rx_ctrl(rx_ctrl), .rx_mode(rx_mode), .rd_strobe(rd_strobe),
    .err_clear(err_clear), .rx_data(rx_data), .rx_ready(rx_ready),
    .brk_flag(brk_flag), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .brk_evt(brk_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic next_tick();
    forever begin
      @(posedge clk);
      if (tcnt == 2'd0) break;
    end
    @(negedge clk);
  endtask

  task automatic hold(input logic v, input int ticks);
    rx_line = v;
    repeat (ticks) next_tick();
  endtask

  function automatic int tpb_of(input logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 16 : (m == 2'b10) ? 32 : 64;
  endfunction

  // sends start, n data bits LSB first, optional parity bit, one stop bit
  task automatic send(input logic [7:0] d, input int n, input bit use_par,
                      input logic pb, input logic stop_v);
    int t = tpb_of(rx_mode[7:6]);
    next_tick();
    hold(1'b0, t);
    for (int i = 0; i < n; i++) hold(d[i], t);
    if (use_par) hold(pb, t);
    hold(stop_v, t);
    if (stop_v) hold(1'b1, 2);
    else next_tick();
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset ready", rx_ready, 0);
    check("R5 reset errors", {par_err, ovr_err}, 0);
    check("R9 reset break", brk_flag, 0);
  endtask

  task automatic t_basic();
    rx_ctrl = 8'hC1; rx_mode = 8'h40;
    send(8'hA5, 8, 0, 0, 1);
    check("R2 data lsb first", rx_data, 8'hA5);
    check("R2 ready", rx_ready, 1);
    check("R8 clean frame", frm_err, 0);
    pulse_rd();
    check("R7 read clears ready", rx_ready, 0);
  endtask

  task automatic t_lengths();
    rx_ctrl = 8'h01; send(8'hF5, 5, 0, 0, 1);
    check("R3 len code 00 -> 5 bits", rx_data, 8'h15); pulse_rd();
    rx_ctrl = 8'h81; send(8'hEA, 6, 0, 0, 1);
    check("R3 len code 10 -> 6 bits", rx_data, 8'h2A); pulse_rd();
    rx_ctrl = 8'h41; send(8'hDB, 7, 0, 0, 1);
    check("R3 len code 01 -> 7 bits", rx_data, 8'h5B); pulse_rd();
    rx_ctrl = 8'hC1;
  endtask

  task automatic t_parity();
    logic [7:0] d = 8'h37;
    rx_mode = 8'h43;
    send(d, 8, 1, ^d, 1);
    check("R4 even parity ok", par_err, 0); pulse_rd();
    send(d, 8, 1, ~^d, 1);
    check("R4 even parity bad", par_err, 1); pulse_rd();
    send(8'h11, 8, 1, 1'b0, 1);
    check("R5 parity error sticky", par_err, 1); pulse_rd();
    pulse_clr();
    check("R5 clear parity", par_err, 0);
    rx_mode = 8'h41;
    send(d, 8, 1, ~^d, 1);
    check("R4 odd parity ok", par_err, 0); pulse_rd();
    send(d, 8, 1, ^d, 1);
    check("R4 odd parity bad", par_err, 1); pulse_rd();
    pulse_clr();
    rx_mode = 8'h40;
  endtask

  task automatic t_overrun();
    send(8'h12, 8, 0, 0, 1);
    check("R6 no overrun first", ovr_err, 0);
    send(8'h34, 8, 0, 0, 1);
    check("R6 overrun set", ovr_err, 1);
    check("R6 buffer overwritten", rx_data, 8'h34);
    pulse_rd();
    send(8'h56, 8, 0, 0, 1);
    check("R5 overrun sticky", ovr_err, 1); pulse_rd();
    pulse_clr();
    check("R5 clear overrun", ovr_err, 0);
  endtask

  task automatic t_framing();
    send(8'h5A, 8, 0, 0, 0);
    check("R8 framing error", frm_err, 1);
    check("R9 not a break", brk_flag, 0);
    hold(1'b1, 3); pulse_rd();
    send(8'h5A, 8, 0, 0, 1);
    check("R8 framing follows char", frm_err, 0); pulse_rd();
  endtask

  task automatic t_break();
    brk_pulses = 0;
    send(8'h00, 8, 0, 0, 0);
    hold(1'b0, 40);
    check("R9 break flag", brk_flag, 1);
    check("R9 break start pulse", brk_pulses, 1);
    check("R10 no restart in break", rx_data, 8'h00);
    hold(1'b1, 3);
    check("R10 break end clears", brk_flag, 0);
    check("R10 break end pulse", brk_pulses, 2);
    pulse_rd(); pulse_clr();
  endtask

  task automatic t_false_start();
    next_tick();
    hold(1'b0, 3);
    hold(1'b1, 40);
    check("R11 false start rejected", rx_ready, 0);
  endtask

  task automatic t_mult();
    rx_mode = 8'h00; send(8'h3C, 8, 0, 0, 1);
    check("R12 x1 data", rx_data, 8'h3C); pulse_rd();
    rx_mode = 8'h80; send(8'hC3, 8, 0, 0, 1);
    check("R12 x32 data", rx_data, 8'hC3); pulse_rd();
    rx_mode = 8'hC0; send(8'h81, 8, 0, 0, 1);
    check("R12 x64 data", rx_data, 8'h81); pulse_rd();
    rx_mode = 8'h40;
  endtask

  task automatic t_disable();
    rx_ctrl = 8'hC0;
    send(8'h99, 8, 1, 1'b1, 0);
    hold(1'b1, 4);
    check("R1 disabled ready", rx_ready, 0);
    check("R1 disabled flags", {par_err, frm_err, brk_flag}, 0);
    rx_ctrl = 8'hC1;
    send(8'h66, 8, 0, 0, 1);
    check("R1 re-enabled", rx_data, 8'h66); pulse_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_overrun();
    t_framing();
    t_break();
    t_false_start();
    t_mult();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule